// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block takes over one bank of a byte-wide parallel flash that is driven with a status-register command set. It can either erase the whole bank or program every byte of it from a local image RAM. It is the only master on a small memory-mapped byte bus. A single start pulse picks the bank and the operation. The block then issues the command bytes and polls the status byte until the flash reports ready, giving up after a bounded number of polls. It clears the status, returns the flash to array-read mode and reads back the entire bank to confirm the result.

Each bank spans `BANK_BYTES` bytes. The bus address is the bank index followed by the byte offset, so a bank's base address is its index times `BANK_BYTES`. Bus transfers use a valid/ready handshake. The block raises `bus_valid` and holds `bus_we`, `bus_addr` and `bus_wdata` unchanged until it sees `bus_ready` high at a clock edge. That edge completes exactly one transfer. For reads, `bus_rdata` is sampled on that same edge. The slave may apply back-pressure for any number of cycles. The image RAM is read through a plain address output; the RAM must present the byte one clock after the address changes.

Top module: `fbp_bank_programmer`

## Requirements
- R1: After reset, and whenever no operation is running, `busy`, `done`, all error flags and `bus_valid` are low.
- R2: A start with `start_op` = 0 (erase) writes 0x20 and then 0xD0 to the bank base address. Every transfer of one operation stays inside the bank selected by `start_bank`.
- R3: Polling writes 0x70 to the bank base and then reads the bank base. The flash counts as finished only once a status read returns bit 7 set; otherwise the write/read pair repeats.
- R4: A start with `start_op` = 1 (program) handles offsets 0 upward. For each offset it writes 0x40 to base+offset, then writes the image byte to the same address, then polls. The data-write handshake comes at least `CLK_MHZ` clock cycles after the setup-write handshake.
- R5: After `POLL_LIMIT` status reads in a row without bit 7, `err_timeout` is set. No further bytes are programmed, and the cleanup and verify steps still run.
- R6: After the erase completes, after the last byte, or after a timeout, the block writes 0x50 and then 0xFF to the bank base before the first verify read.
- R7: Erase verify reads the bank offsets in ascending order and expects 0xFF from each. The first mismatch sets `err_verify` and ends the read-back.
- R8: Program verify reads the bank offsets in ascending order and compares each one with the image byte. The first mismatch sets `err_verify` and ends the read-back.
- R9: A ready status byte with any bit of 0x38 set raises `err_status`. The operation carries on.
- R10: Each transfer is a single valid/ready handshake, with the request held stable while `bus_ready` is low.
- R11: `done` rises when `busy` falls. `done` and the error flags hold until the next accepted start, which clears them. A start while `busy` is ignored.
- R12: `img_addr` carries the byte offset being programmed or verified. `img_data` is taken one cycle after the address changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_bank | input | BANK_SEL_W | Bank index for the operation |
| start_op | input | 1 | 0 erase, 1 program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished, held until next start |
| err_timeout | output | 1 | Status polling limit reached |
| err_verify | output | 1 | Read-back mismatch |
| err_status | output | 1 | Ready status carried an error bit |
| bus_valid | output | 1 | Transfer request |
| bus_ready | input | 1 | Transfer accepted by flash side |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | BANK_SEL_W+log2(BANK_BYTES) | Byte address: bank, offset |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid on handshake |
| img_addr | output | log2(BANK_BYTES) | Image RAM byte offset |
| img_data | input | 8 | Image RAM byte, one cycle after address |

## Verification
A sequencer in the wrong state shows up on the bus within a single transfer. Examples are a command byte out of order, a missing 0x50/0xFF pair before the read-back, or an address outside the selected bank. The bench therefore records every handshake and compares the full log against the sequence it expects. A wrong byte counter or poll counter shows up at the end of the bank: the log length, the number of status reads before a timeout, or the point where the read-back stops will differ. Flag faults appear when `busy` falls and stay visible until the next start.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] STAT_ERR_MASK   = 8'h38;
  localparam int         STAT_READY_BIT  = 7;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

  typedef enum logic {OP_ERASE = 1'b0, OP_PROGRAM = 1'b1} fbp_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ER_SETUP, ST_ER_GO, ST_PG_SETUP, ST_PG_GAP, ST_PG_DATA,
    ST_POLL_CMD, ST_POLL_RD, ST_CLR, ST_RST, ST_VF_WAIT, ST_VF_RD, ST_FIN
  } fbp_state_e;
endpackage

// File: rtl/fbp_count.sv
module fbp_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (inc)      q <= q + W'(1);
  end
endmodule

// File: rtl/fbp_gap.sv
module fbp_gap #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= W'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0) && !load;
endmodule

// File: rtl/fbp_bank_programmer.sv
module fbp_bank_programmer
  import fbp_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int BANK_SEL_W = 1,
  parameter int CLK_MHZ    = 100,
  parameter int POLL_LIMIT = 1000000,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = BANK_SEL_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BANK_SEL_W-1:0] start_bank,
  input  logic                  start_op,
  output logic                  busy,
  output logic                  done,
  output logic                  err_timeout,
  output logic                  err_verify,
  output logic                  err_status,
  output logic                  bus_valid,
  input  logic                  bus_ready,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [7:0]            bus_wdata,
  input  logic [7:0]            bus_rdata,
  output logic [OFF_W-1:0]      img_addr,
  input  logic [7:0]            img_data
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  fbp_state_e            state, state_nx;
  logic [BANK_SEL_W-1:0] bank_q;
  fbp_op_e               op_q;
  logic [OFF_W-1:0]      idx;
  logic [POLL_W-1:0]     polls;
  logic [OFF_W-1:0]      off;
  logic                  hs, last_byte, gap_done;
  logic                  idx_clr, idx_inc, poll_clr, poll_inc, gap_load;
  logic                  set_to, set_vf, set_st, accept;
  logic [7:0]            expect_byte;

  fbp_count #(.W(OFF_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc), .q(idx)
  );

  fbp_count #(.W(POLL_W)) u_polls (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .q(polls)
  );

  fbp_gap #(.CYCLES(CLK_MHZ)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_done)
  );

  assign hs          = bus_valid && bus_ready;
  assign last_byte   = (idx == OFF_W'(BANK_BYTES - 1));
  assign busy        = (state != ST_IDLE);
  assign img_addr    = idx;
  assign bus_addr    = {bank_q, off};
  assign expect_byte = (op_q == OP_PROGRAM) ? img_data : ERASED_BYTE;
  assign accept      = (state == ST_IDLE) && start;

  // Bus request decode: the payload depends only on state and stable counters.
  always_comb begin
    bus_valid = 1'b1;
    bus_we    = 1'b1;
    bus_wdata = 8'h00;
    off       = '0;
    unique case (state)
      ST_ER_SETUP: bus_wdata = CMD_ERASE_SETUP;
      ST_ER_GO:    bus_wdata = CMD_ERASE_GO;
      ST_PG_SETUP: begin bus_wdata = CMD_PROG_SETUP; off = idx; end
      ST_PG_DATA:  begin bus_wdata = img_data;       off = idx; end
      ST_POLL_CMD: bus_wdata = CMD_STATUS;
      ST_POLL_RD:  bus_we    = 1'b0;
      ST_CLR:      bus_wdata = CMD_CLEAR;
      ST_RST:      bus_wdata = CMD_READ_ARRAY;
      ST_VF_RD:    begin bus_we = 1'b0; off = idx; end
      default:     begin bus_valid = 1'b0; bus_we = 1'b0; end
    endcase
  end

  // Sequencing.
  always_comb begin
    state_nx = state;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    gap_load = 1'b0;
    set_to   = 1'b0;
    set_vf   = 1'b0;
    set_st   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        idx_clr  = 1'b1;
        poll_clr = 1'b1;
        state_nx = start_op ? ST_PG_SETUP : ST_ER_SETUP;
      end
      ST_ER_SETUP: if (hs) state_nx = ST_ER_GO;
      ST_ER_GO:    if (hs) state_nx = ST_POLL_CMD;
      ST_PG_SETUP: if (hs) begin gap_load = 1'b1; state_nx = ST_PG_GAP; end
      ST_PG_GAP:   if (gap_done) state_nx = ST_PG_DATA;
      ST_PG_DATA:  if (hs) state_nx = ST_POLL_CMD;
      ST_POLL_CMD: if (hs) state_nx = ST_POLL_RD;
      ST_POLL_RD: if (hs) begin
        if (bus_rdata[STAT_READY_BIT]) begin
          set_st   = |(bus_rdata & STAT_ERR_MASK);
          poll_clr = 1'b1;
          if (op_q == OP_PROGRAM && !last_byte) begin
            idx_inc  = 1'b1;
            state_nx = ST_PG_SETUP;
          end else begin
            state_nx = ST_CLR;
          end
        end else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
          set_to   = 1'b1;
          state_nx = ST_CLR;
        end else begin
          poll_inc = 1'b1;
          state_nx = ST_POLL_CMD;
        end
      end
      ST_CLR: if (hs) state_nx = ST_RST;
      ST_RST: if (hs) begin idx_clr = 1'b1; state_nx = ST_VF_WAIT; end
      ST_VF_WAIT: state_nx = ST_VF_RD;
      ST_VF_RD: if (hs) begin
        if (bus_rdata != expect_byte) begin
          set_vf   = 1'b1;
          state_nx = ST_FIN;
        end else if (last_byte) begin
          state_nx = ST_FIN;
        end else begin
          idx_inc  = 1'b1;
          state_nx = ST_VF_WAIT;
        end
      end
      ST_FIN:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bank_q      <= '0;
      op_q        <= OP_ERASE;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_verify  <= 1'b0;
      err_status  <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        bank_q      <= start_bank;
        op_q        <= fbp_op_e'(start_op);
        done        <= 1'b0;
        err_timeout <= 1'b0;
        err_verify  <= 1'b0;
        err_status  <= 1'b0;
      end else begin
        if (state == ST_FIN) done <= 1'b1;
        if (set_to) err_timeout <= 1'b1;
        if (set_vf) err_verify  <= 1'b1;
        if (set_st) err_status  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbp_bank_programmer_chk.sv
module fbp_bank_programmer_chk #(
  parameter int BANK_SEL_W = 1,
  parameter int OFF_W      = 13,
  localparam int ADDR_W    = BANK_SEL_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err_timeout,
  input logic              err_verify,
  input logic              err_status,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid); // R1

  AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && $past(bus_valid) |-> $stable(bus_addr[ADDR_W-1:OFF_W])); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({done, err_timeout, err_verify, err_status})); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done && !err_timeout && !err_verify && !err_status); // R11
endmodule

bind fbp_bank_programmer fbp_bank_programmer_chk #(
  .BANK_SEL_W(BANK_SEL_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_timeout(err_timeout), .err_verify(err_verify), .err_status(err_status),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/fbp_bank_programmer_tb.sv
module fbp_bank_programmer_tb;
  localparam int BB  = 16;
  localparam int BSW = 1;
  localparam int MHZ = 4;
  localparam int PL  = 8;
  localparam int OW  = 4;
  localparam int AW  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_op = 1'b0;
  logic [BSW-1:0] start_bank = '0;
  logic busy, done, err_timeout, err_verify, err_status;
  logic bus_valid, bus_we;
  logic bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = 8'h00;
  logic [OW-1:0] img_addr;
  logic [7:0] img_data = 8'h00;

  always #5 clk = ~clk;

  fbp_bank_programmer #(.BANK_BYTES(BB), .BANK_SEL_W(BSW), .CLK_MHZ(MHZ), .POLL_LIMIT(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bank(start_bank), .start_op(start_op),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
    .err_status(err_status), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .img_addr(img_addr), .img_data(img_data)
  );

  // Image RAM, one cycle read latency.
  logic [7:0] img [0:BB-1];
  always @(posedge clk) img_data <= img[img_addr];

  // Flash model and transfer log.
  logic [7:0] fmem [0:2*BB-1];
  int pend = 0, busy_polls = 0, lat = 1, lat_cnt = 0, cyc = 0;
  int stuck_addr = -1;
  logic [7:0] stuck_mask = 8'h00, serr_bits = 8'h00;
  bit stat_mode = 0, prog_arm = 0, erase_arm = 0;
  logic [AW-1:0] lg_addr [0:511];
  logic          lg_we   [0:511];
  logic [7:0]    lg_data [0:511];
  int            lg_time [0:511];
  int lg_n = 0;
  int tests = 0, fails = 0;

  function automatic logic [7:0] rd_value(input logic [AW-1:0] a);
    if (stat_mode) return (pend > 0) ? 8'h00 : (8'h80 | serr_bits);
    return fmem[a] & ((int'(a) == stuck_addr) ? ~stuck_mask : 8'hFF);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      bus_ready <= 1'b0;
      lat_cnt = 0;
    end else if (bus_valid && bus_ready) begin
      if (lg_n < 512) begin
        lg_addr[lg_n] = bus_addr; lg_we[lg_n] = bus_we;
        lg_data[lg_n] = bus_we ? bus_wdata : bus_rdata; lg_time[lg_n] = cyc;
        lg_n = lg_n + 1;
      end
      if (!bus_we) begin
        if (stat_mode && pend > 0) pend = pend - 1;
      end else if (prog_arm) begin
        fmem[bus_addr] = fmem[bus_addr] & bus_wdata;
        prog_arm = 0; stat_mode = 1; pend = busy_polls;
      end else begin
        case (bus_wdata)
          8'h20: erase_arm = 1;
          8'hD0: if (erase_arm) begin
            for (int i = 0; i < BB; i++) fmem[int'(bus_addr[AW-1:OW]) * BB + i] = 8'hFF;
            erase_arm = 0; stat_mode = 1; pend = busy_polls;
          end
          8'h40: prog_arm = 1;
          8'h70: stat_mode = 1;
          8'h50: serr_bits = 8'h00;
          8'hFF: stat_mode = 0;
          default: ;
        endcase
      end
      bus_ready <= 1'b0;
      lat_cnt = 0;
    end else if (bus_valid) begin
      if (lat_cnt >= lat) begin
        bus_ready <= 1'b1;
        bus_rdata <= rd_value(bus_addr);
      end else lat_cnt = lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input int polls, input int latency);
    busy_polls = polls; lat = latency; pend = 0; serr_bits = 8'h00;
    stuck_addr = -1; stuck_mask = 8'h00; stat_mode = 0; prog_arm = 0; erase_arm = 0;
    lg_n = 0;
  endtask

  task automatic run_op(input int bank, input bit op);
    @(negedge clk);
    start_bank = BSW'(bank); start_op = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    chk(!err_timeout && !err_verify && !err_status, "R1 flags after reset",
        {err_timeout, err_verify, err_status}, 0);
    chk(!bus_valid, "R1 bus idle", bus_valid, 0);
  endtask

  task automatic t_erase;
    bit bad;
    setup(3, 1);
    for (int i = 0; i < BB; i++) fmem[BB + i] = 8'(i * 7);
    run_op(1, 1'b0);
    chk(lg_n == 28, "R7 erase transfer count", lg_n, 28);
    chk(lg_we[0] && lg_data[0] == 8'h20 && int'(lg_addr[0]) == BB, "R2 erase setup", lg_data[0], 8'h20);
    chk(lg_we[1] && lg_data[1] == 8'hD0 && int'(lg_addr[1]) == BB, "R2 erase confirm", lg_data[1], 8'hD0);
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      if (!(lg_we[2+2*k] && lg_data[2+2*k] == 8'h70 && int'(lg_addr[2+2*k]) == BB)) bad = 1;
      if (lg_we[3+2*k] || int'(lg_addr[3+2*k]) != BB) bad = 1;
    end
    chk(!bad && lg_data[9] == 8'h80, "R3 poll pairs until ready", lg_data[9], 8'h80);
    chk(lg_data[10] == 8'h50 && lg_data[11] == 8'hFF && lg_we[10] && lg_we[11], "R6 cleanup order",
        {lg_data[10], lg_data[11]}, 16'h50FF);
    bad = 0;
    for (int i = 0; i < BB; i++)
      if (lg_we[12+i] || int'(lg_addr[12+i]) != BB + i) bad = 1;
    chk(!bad, "R7 verify reads ascend over bank", bad, 0);
    chk(done && !busy && !err_timeout && !err_verify && !err_status, "R11 clean erase result",
        {err_timeout, err_verify, err_status}, 0);
  endtask

  task automatic t_program;
    bit bad;
    int min_gap;
    setup(1, 0);
    for (int i = 0; i < BB; i++) begin fmem[i] = 8'hFF; img[i] = 8'(i * 29 + 5); end
    run_op(0, 1'b1);
    chk(lg_n == 114, "R4 program transfer count", lg_n, 114);
    bad = 0; min_gap = 1000;
    for (int i = 0; i < BB; i++) begin
      int b = 6 * i;
      if (!(lg_we[b] && lg_data[b] == 8'h40 && int'(lg_addr[b]) == i)) bad = 1;
      if (!(lg_we[b+1] && lg_data[b+1] == img[i] && int'(lg_addr[b+1]) == i)) bad = 1;
      if (!(lg_data[b+2] == 8'h70 && !lg_we[b+3] && lg_data[b+4] == 8'h70 && !lg_we[b+5])) bad = 1;
      if (lg_time[b+1] - lg_time[b] < min_gap) min_gap = lg_time[b+1] - lg_time[b];
    end
    chk(!bad, "R4 R12 per-byte setup/data/poll with image byte", bad, 0);
    chk(min_gap >= MHZ, "R4 setup-to-data gap", min_gap, MHZ);
    chk(lg_data[96] == 8'h50 && lg_data[97] == 8'hFF, "R6 cleanup after last byte",
        {lg_data[96], lg_data[97]}, 16'h50FF);
    bad = 0;
    for (int i = 0; i < BB; i++) if (fmem[i] != img[i]) bad = 1;
    chk(!bad && done && !err_verify && !err_timeout, "R8 program verify passes", err_verify, 0);
  endtask

  task automatic t_erase_verify_fail;
    setup(0, 1);
    stuck_addr = 5; stuck_mask = 8'h01;
    run_op(0, 1'b0);
    chk(err_verify && done, "R7 erase mismatch flagged", err_verify, 1);
    chk(lg_n == 12, "R7 read-back stops at first mismatch", lg_n, 12);
  endtask

  task automatic t_program_verify_fail;
    setup(0, 1);
    for (int i = 0; i < BB; i++) begin fmem[BB + i] = 8'hFF; img[i] = 8'hF0 ^ 8'(i); end
    fmem[BB + 3] = 8'h0F; img[3] = 8'hF0;
    run_op(1, 1'b1);
    chk(err_verify && done && !err_timeout, "R8 program mismatch flagged", err_verify, 1);
    chk(lg_n == 70, "R8 read-back stops at byte 3", lg_n, 70);
  endtask

  task automatic t_timeout;
    int setups;
    setup(100, 0);
    for (int i = 0; i < BB; i++) begin fmem[i] = 8'hFF; img[i] = 8'hFF; end
    run_op(0, 1'b1);
    chk(err_timeout && done, "R5 timeout flagged", err_timeout, 1);
    setups = 0;
    for (int k = 0; k < lg_n; k++) if (lg_we[k] && lg_data[k] == 8'h40) setups++;
    chk(setups == 1, "R5 byte loop stops", setups, 1);
    chk(lg_n == 36, "R5 poll limit then cleanup and verify", lg_n, 36);
    chk(lg_data[18] == 8'h50 && lg_data[19] == 8'hFF, "R6 cleanup after timeout",
        {lg_data[18], lg_data[19]}, 16'h50FF);
    chk(!err_verify, "R5 verify still runs clean", err_verify, 0);
  endtask

  task automatic t_status_err;
    setup(2, 1);
    serr_bits = 8'h10;
    run_op(1, 1'b0);
    chk(err_status && done && !err_verify, "R9 status error bit flagged", err_status, 1);
    repeat (10) @(negedge clk);
    chk(done && err_status, "R11 flags held while idle", {done, err_status}, 3);
  endtask

  task automatic t_ignore_start;
    bit bad;
    int setups;
    setup(2, 2);
    @(negedge clk);
    start_bank = 1'b0; start_op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !err_status, "R11 start clears flags", {done, err_status}, 0);
    repeat (3) @(negedge clk);
    start_bank = 1'b1; start_op = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    bad = 0; setups = 0;
    for (int k = 0; k < lg_n; k++) begin
      if (lg_addr[k][AW-1] != 1'b0) bad = 1;
      if (lg_we[k] && lg_data[k] == 8'h40) setups++;
    end
    chk(!bad && setups == 0, "R11 start during busy ignored", setups, 0);
    chk(lg_n == 26, "R10 one transfer per handshake under back-pressure", lg_n, 26);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2 * BB; i++) fmem[i] = 8'hFF;
    for (int i = 0; i < BB; i++) img[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_erase();
    t_program();
    t_erase_verify_fail();
    t_program_verify_fail();
    t_timeout();
    t_status_err();
    t_ignore_start();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule